// File: doc/BRIEF.md
# Serial Slave-Address Wake-Up Controller

This block is the control and status front end of a byte-oriented serial channel. A processor programs it through a small register bus. One control register holds the channel enable, a wake-up enable, a three-bit transfer-mode field and a two-bit shift-clock source field. A separate register holds the slave address. Each byte that the serial engine delivers is kept as the shift-register contents. A live comparison flag reports whether that byte equals the slave address, and it reads as zero while the channel is off.

The block produces one interrupt pulse per received byte. With wake-up off, every byte raises it. With wake-up on, only the first byte after a qualified bus release can raise it, and only when that byte matches the slave address. A bus release is qualified when the command-detect and release-detect indications are both high. A separate interrupt-timing input, when high, overrides wake-up mode and restores the every-byte behaviour.

The address-arming state machine has three states:
- `ST_OFF`: the channel is disabled.
- `ST_WAIT`: the channel is enabled and waiting for a qualified release.
- `ST_ARMED`: the next byte is treated as an address.

Its transitions are:
- `ST_OFF` to `ST_WAIT` once the channel is enabled.
- `ST_WAIT` to `ST_ARMED` on a qualified release.
- `ST_ARMED` stays in `ST_ARMED` on another qualified release.
- `ST_ARMED` to `ST_WAIT` when a byte is evaluated or an unqualified release occurs.
- Any state to `ST_OFF` whenever the enable bit is low.

Top module: `sa_wake_ctrl`

## Requirements
- R1: After reset, the control register (register address 0) reads 0x00, the slave-address register (register address 1) reads 0x00, `irq` is 0, `chan_en` is 0 and `clk_src` is 0.
- R2: A write to register address 0 stores bit 7 (enable), bit 5 (wake-up) and bits 4..2 (output on `xfer_mode`) and bits 1..0; the written value of bit 6 has no effect on what is read back.
- R3: Bit 6 of a control-register read is 1 exactly when the channel is enabled and the slave address equals the last received byte; it reads 0 whenever bit 7 is 0.
- R4: `clk_src` decodes control bits 1..0: 00 or 01 give 0 (external pin), 10 gives 1 (timer output), 11 gives 2 (prescaled clock).
- R5: With the channel enabled and wake-up off, every received byte produces `irq` high in the cycle after `rx_valid`.
- R6: While the channel is disabled, received bytes raise no interrupt, and a bus release seen while disabled does not arm the wake-up logic after enabling.
- R7: With wake-up on, the first byte after a qualified release raises `irq` only if it equals the slave address.
- R8: A bus release with command-detect or release-detect low does not arm the wake-up logic.
- R9: Once the first byte after a release has been evaluated, later bytes raise no interrupt in wake-up mode even when they match.
- R10: While `timing_hold` is 1, wake-up mode is suppressed and every byte raises an interrupt; clearing it restores wake-up gating.
- R11: `irq` is high for one cycle per received byte and never without a byte in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 slave address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_valid | input | 1 | Byte-received strobe |
| rx_byte | input | 8 | Shift-register byte delivered with `rx_valid` |
| bus_release | input | 1 | Bus-release strobe from the serial engine |
| cmd_detect | input | 1 | Command-detect indication, sampled with `bus_release` |
| rel_detect | input | 1 | Release-detect indication, sampled with `bus_release` |
| timing_hold | input | 1 | Interrupt-timing control; 1 suppresses wake-up mode |
| chan_en | output | 1 | Channel enable (control bit 7) |
| xfer_mode | output | 3 | Transfer-mode field (control bits 4..2) |
| clk_src | output | 2 | Decoded shift-clock source |
| irq | output | 1 | Transfer interrupt pulse |

## Verification
The in-line assertions watch, on every cycle, that the interrupt follows a byte and an enabled channel, that wake-up mode never lets a non-matching or unarmed byte through, and that the arming state only rises on a qualified release. They also check that arming drops after a byte and that the match flag stays clear while the channel is off. Only the bench scenarios can show the full register view: masking of the read-only bit, the clock-source decode values, and stale releases seen while disabled. They also show the exact order of interrupts across release, mismatch, re-match and timing-override sequences.

// File: rtl/sawk_pkg.sv
package sawk_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_EN    = 7;
    localparam int BIT_MATCH = 6;
    localparam int BIT_WAKE  = 5;
    localparam int MODE_LO   = 2;
    localparam int MODE_W    = 3;
    localparam int CSRC_W    = 2;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ARMED = 2'd2
    } arm_state_t;

    typedef enum logic [1:0] {
        SRC_EXT_PIN  = 2'd0,
        SRC_TIMER    = 2'd1,
        SRC_PRESCALE = 2'd2
    } clk_src_t;
endpackage

// File: rtl/sawk_regfile.sv
module sawk_regfile
    import sawk_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] SVA_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              chan_en,
    output logic              wake_en,
    output logic [MODE_W-1:0] mode_bits,
    output logic [CSRC_W-1:0] clk_bits,
    output logic [BYTE_W-1:0] slave_addr
);
    localparam logic [BYTE_W-1:0] RO_MASK = BYTE_W'(1) << BIT_MATCH;

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] sva_q;
    logic [BYTE_W-1:0] shift_q;
    logic              match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            sva_q   <= '0;
            shift_q <= '0;
        end else begin
            if (reg_we && reg_addr == CTRL_ADDR) ctrl_q <= reg_wdata & ~RO_MASK;
            if (reg_we && reg_addr == SVA_ADDR)  sva_q  <= reg_wdata;
            if (rx_valid)                        shift_q <= rx_byte;
        end
    end

    assign match = ctrl_q[BIT_EN] && (sva_q == shift_q);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata            = ctrl_q;
            reg_rdata[BIT_MATCH] = match;
        end else if (reg_addr == SVA_ADDR) begin
            reg_rdata = sva_q;
        end
    end

    assign chan_en    = ctrl_q[BIT_EN];
    assign wake_en    = ctrl_q[BIT_WAKE];
    assign mode_bits  = ctrl_q[MODE_LO +: MODE_W];
    assign clk_bits   = ctrl_q[CSRC_W-1:0];
    assign slave_addr = sva_q;

    AST_MATCH_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CTRL_ADDR && !chan_en) |-> !reg_rdata[BIT_MATCH]); // R3
endmodule

// File: rtl/sawk_clk_decode.sv
module sawk_clk_decode
    import sawk_pkg::*;
(
    input  logic [CSRC_W-1:0] clk_bits,
    output clk_src_t          clk_src
);
    always_comb begin
        unique case (clk_bits)
            2'b00, 2'b01: clk_src = SRC_EXT_PIN;
            2'b10:        clk_src = SRC_TIMER;
            2'b11:        clk_src = SRC_PRESCALE;
            default:      clk_src = SRC_EXT_PIN;
        endcase
    end
endmodule

// File: rtl/sawk_arm_fsm.sv
module sawk_arm_fsm
    import sawk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic bus_release,
    input  logic cmd_detect,
    input  logic rel_detect,
    input  logic rx_valid,
    output logic armed
);
    arm_state_t state_q, state_d;
    logic       qual_rel;

    assign qual_rel = bus_release && cmd_detect && rel_detect;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (chan_en) state_d = ST_WAIT;
            ST_WAIT:  if (qual_rel) state_d = ST_ARMED;
            ST_ARMED: begin
                if (qual_rel)                      state_d = ST_ARMED;
                else if (rx_valid || bus_release)  state_d = ST_WAIT;
            end
            default:  state_d = ST_OFF;
        endcase
        if (!chan_en) state_d = ST_OFF;
    end

    always_comb begin
        armed = (state_q == ST_ARMED);
    end

    AST_ARM_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(bus_release && cmd_detect && rel_detect)); // R8
    AST_DISARM_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rx_valid && !(bus_release && cmd_detect && rel_detect)) |=> !armed); // R9
    AST_OFF_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !armed); // R6
endmodule

// File: rtl/sawk_irq_gate.sv
module sawk_irq_gate
    import sawk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              wake_en,
    input  logic              timing_hold,
    input  logic              armed,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] slave_addr,
    output logic              irq
);
    logic wake_eff;
    logic addr_hit;
    logic fire;

    assign wake_eff = wake_en && !timing_hold;
    assign addr_hit = (rx_byte == slave_addr);
    assign fire     = chan_en && rx_valid && (!wake_eff || (armed && addr_hit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end

    AST_IRQ_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_valid)); // R11
    AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(chan_en)); // R6
    AST_WAKE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(wake_en && !timing_hold)) |-> $past(armed && rx_byte == slave_addr)); // R7
    AST_PLAIN_EVERY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && rx_valid && !wake_en) |=> irq); // R5
endmodule

// File: rtl/sa_wake_ctrl.sv
module sa_wake_ctrl
    import sawk_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              bus_release,
    input  logic              cmd_detect,
    input  logic              rel_detect,
    input  logic              timing_hold,
    output logic              chan_en,
    output logic [MODE_W-1:0] xfer_mode,
    output logic [CSRC_W-1:0] clk_src,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] CTRL_A = '0;
    localparam logic [ADDR_W-1:0] SVA_A  = ADDR_W'(1);

    logic              wake_en;
    logic [CSRC_W-1:0] clk_bits;
    logic [BYTE_W-1:0] slave_addr;
    logic              armed;
    clk_src_t          src_dec;

    sawk_regfile #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_A),
        .SVA_ADDR  (SVA_A)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_rdata  (reg_rdata),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .chan_en    (chan_en),
        .wake_en    (wake_en),
        .mode_bits  (xfer_mode),
        .clk_bits   (clk_bits),
        .slave_addr (slave_addr)
    );

    sawk_clk_decode u_csrc (
        .clk_bits (clk_bits),
        .clk_src  (src_dec)
    );
    assign clk_src = src_dec;

    sawk_arm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .bus_release (bus_release),
        .cmd_detect  (cmd_detect),
        .rel_detect  (rel_detect),
        .rx_valid    (rx_valid),
        .armed       (armed)
    );

    sawk_irq_gate u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .wake_en     (wake_en),
        .timing_hold (timing_hold),
        .armed       (armed),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .slave_addr  (slave_addr),
        .irq         (irq)
    );
endmodule

// File: tb/test_sa_wake_ctrl.sv
module test_sa_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       bus_release = 1'b0;
    logic       cmd_detect = 1'b0;
    logic       rel_detect = 1'b0;
    logic       timing_hold = 1'b0;
    logic       chan_en;
    logic [2:0] xfer_mode;
    logic [1:0] clk_src;
    logic       irq;

    int compared = 0;
    int mismatched = 0;
    bit    exp_q[$];
    string tag_q[$];
    logic  mon_v;

    always #2 clk = ~clk;

    sa_wake_ctrl i_sa_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bus_release(bus_release), .cmd_detect(cmd_detect), .rel_detect(rel_detect),
        .timing_hold(timing_hold), .chan_en(chan_en), .xfer_mode(xfer_mode),
        .clk_src(clk_src), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, int exp, string req);
        @(negedge clk); reg_addr = a; #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic release_bus(logic c, logic r);
        @(negedge clk); bus_release = 1'b1; cmd_detect = c; rel_detect = r;
        @(negedge clk); bus_release = 1'b0; cmd_detect = 1'b0; rel_detect = 1'b0;
    endtask

    // driver: pushes the expected interrupt outcome for each byte
    task automatic send_byte(logic [7:0] b, bit exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    // monitor: irq is checked just after each edge
    always @(posedge clk) begin
        mon_v = rx_valid;
        #1;
        if (rst_n) begin
            if (mon_v) begin
                if (exp_q.size() == 0) begin
                    chk("R11 (no expected item)", 1, 0);
                end else begin
                    string t;
                    bit e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, int'(irq), int'(e));
                end
            end else if (irq) begin
                chk("R11", int'(irq), 0);
            end
        end
    end

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(2'd0, 8'h00, "R1 ctrl");
        rd_chk(2'd1, 8'h00, "R1 sva");
        chk("R1 irq", int'(irq), 0);
        chk("R1 chan_en", int'(chan_en), 0);
        chk("R1 clk_src", int'(clk_src), 0);

        // R2 / R4 register fields and clock decode
        wr(2'd1, 8'h5A);
        rd_chk(2'd1, 8'h5A, "R2 sva");
        wr(2'd0, 8'hFF);
        rd_chk(2'd0, 8'hBF, "R2 bit6 ignored");
        chk("R2 xfer_mode", int'(xfer_mode), 7);
        chk("R4 clk 11", int'(clk_src), 2);
        wr(2'd0, 8'hC2);
        rd_chk(2'd0, 8'h82, "R2 bit6 ignored");
        chk("R4 clk 10", int'(clk_src), 1);
        wr(2'd0, 8'h81);
        chk("R4 clk 01", int'(clk_src), 0);
        wr(2'd0, 8'h80);
        chk("R4 clk 00", int'(clk_src), 0);
        chk("R2 chan_en", int'(chan_en), 1);

        // R5 wake-up off: every byte
        send_byte(8'h11, 1'b1, "R5");
        send_byte(8'h5A, 1'b1, "R5");
        rd_chk(2'd0, 8'hC0, "R3 match set");
        send_byte(8'h12, 1'b1, "R5");
        rd_chk(2'd0, 8'h80, "R3 match clear");
        send_byte(8'h5A, 1'b1, "R5");

        // R6 disabled channel
        wr(2'd0, 8'h00);
        send_byte(8'h5A, 1'b0, "R6");
        rd_chk(2'd0, 8'h00, "R3 flag off when disabled");
        release_bus(1'b1, 1'b1);
        wr(2'd0, 8'hA0);
        send_byte(8'h5A, 1'b0, "R6 stale release");
        rd_chk(2'd0, 8'hE0, "R3 match enabled");

        // R8 unqualified releases
        release_bus(1'b1, 1'b0);
        send_byte(8'h5A, 1'b0, "R8");
        release_bus(1'b0, 1'b1);
        send_byte(8'h5A, 1'b0, "R8");

        // R7 / R9 wake-up gating
        release_bus(1'b1, 1'b1);
        send_byte(8'h33, 1'b0, "R7 mismatch");
        send_byte(8'h5A, 1'b0, "R9");
        release_bus(1'b1, 1'b1);
        send_byte(8'h5A, 1'b1, "R7 match");
        send_byte(8'h5A, 1'b0, "R9");
        wr(2'd1, 8'h21);
        release_bus(1'b1, 1'b1);
        send_byte(8'h21, 1'b1, "R7 new address");

        // R10 timing override
        timing_hold = 1'b1;
        send_byte(8'h44, 1'b1, "R10");
        send_byte(8'h45, 1'b1, "R10");
        @(negedge clk); timing_hold = 1'b0;
        send_byte(8'h21, 1'b0, "R10 restored");

        repeat (4) @(negedge clk);
        chk("R11 queue drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule